// File: doc/BRIEF.md
# Four-Pin GPIO Slice with Edge-Triggered Interrupts

This block is a four-pin slice of a general-purpose I/O port. One 8-bit control register holds a 2-bit mode field for each pin. The field sets both the pin's direction and, for an input, which edges raise an interrupt. A pin can be a push-pull output that drives its bit of an output data register. Otherwise it is an input that flags rising edges, falling edges, or both. Each pin input passes through a two-flop synchronizer before its edges are detected.

Each detected edge sets a pending flag for its pin. All four flags merge into a single registered interrupt request. Software reads the flags and clears them by writing ones. A small register bus gives access to four locations: mode control, output data, pending flags and the synchronized pin levels. Read data is registered.

Top module: `gpio_nibble_irq`

## Requirements
- R1: After synchronous reset, the mode register, output data, pending flags and `irq` are all 0, `pin_oe` is 0, and every pin starts in falling-edge input mode.
- R2: Mode 2'b00 sets the pin's pending flag on a falling edge of its synchronized input and never on a rising edge.
- R3: Mode 2'b01 sets the pin's pending flag on both rising and falling edges.
- R4: Mode 2'b11 sets the pin's pending flag on a rising edge and never on a falling edge.
- R5: In mode 2'b10, `pin_oe` for that pin is 1 and `pin_out` follows its output data bit. Changes on that pin's input never set its pending flag. In every other mode, `pin_oe` is 0.
- R6: The mode field for pin i sits at control bits [2i+1:2i], so bits 7:6 govern pin 3 and bits 1:0 govern pin 0.
- R7: `irq` equals the OR of the four pending flags as they stood one clock earlier.
- R8: Writing to address 2 clears each pending flag whose data bit is 1 and leaves flags written with 0 unchanged. An enabled edge in the same cycle as a clear wins, and the flag stays set.
- R9: Writing a new mode to a pin reloads its previous-value register from the current synchronized input. A mode change on its own therefore never sets the pending flag, even when the pin level changed while the pin was an output.
- R10: A pin change reaches the edge detector through two synchronizer flops. When the input changes before clock edge k, the pending flag is set at edge k+2 and `irq` rises at edge k+3.
- R11: Reads are registered. After the edge on which `bus_addr` is sampled, `bus_rdata` holds the value at that address: 0 is the mode register, 1 is the output data in bits 3:0, 2 is the pending flags in bits 3:0, and 3 is the synchronized pin levels in bits 3:0. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 4 | Asynchronous pin levels from the pads |
| pin_out | output | 4 | Output data toward the pads |
| pin_oe | output | 4 | Per-pin output enable |
| irq | output | 1 | Shared registered interrupt request |

## Verification
The in-module properties take the synchronizer output as an ordinary clocked signal. They also assume that the bus strobe and data are never X after reset. The edge and clear properties are stated against the mode held in the register, so they assume that a mode write takes effect only from the following cycle.

The stimulus keeps to these assumptions. All inputs, including `pin_in`, are driven on the falling clock edge. Each write is held for exactly one cycle. Every pin change is held long enough to pass the synchronizer. The random phase mixes mode writes, clears and pin toggles freely, so that some clears coincide with edges.

// File: rtl/gpio_nib_pkg.sv
package gpio_nib_pkg;
  typedef enum logic [1:0] {
    MD_FALL  = 2'b00,
    MD_BOTH  = 2'b01,
    MD_DRIVE = 2'b10,
    MD_RISE  = 2'b11
  } pin_mode_e;

  localparam logic [1:0] RA_MODE = 2'd0;
  localparam logic [1:0] RA_DOUT = 2'd1;
  localparam logic [1:0] RA_PEND = 2'd2;
  localparam logic [1:0] RA_LVL  = 2'd3;
endpackage

// File: rtl/gpio_nib_sync.sv
module gpio_nib_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_nib_edge.sv
module gpio_nib_edge
  import gpio_nib_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pin_mode_e mode_i,
  input  logic      sync_i,
  input  logic      reload_i,
  input  logic      clr_i,
  output logic      pend_o
);
  logic prev_q, pend_q;
  logic rise_w, fall_w, hit_w;

  always_comb begin
    rise_w = sync_i & ~prev_q;
    fall_w = ~sync_i & prev_q;
    unique case (mode_i)
      MD_FALL: hit_w = fall_w;
      MD_BOTH: hit_w = rise_w | fall_w;
      MD_RISE: hit_w = rise_w;
      default: hit_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (reload_i || mode_i != MD_DRIVE) prev_q <= sync_i;
      if (hit_w)      pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R2: a pin in falling mode whose level is high saw no falling edge
  p_fall_only_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_FALL && sync_i) |=> !$rose(pend_q));
  // R4: a pin in rising mode whose level is low saw no rising edge
  p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_RISE && !sync_i) |=> !$rose(pend_q));
  // R5: an output pin never raises its flag
  p_drive_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_DRIVE) |=> !$rose(pend_q));
  // R8: a clear with no competing edge source drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && mode_i == MD_DRIVE) |=> !pend_q);
  // R3: in both-edge mode any level change is recorded
  p_both_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_BOTH && sync_i != prev_q) |=> pend_q);
endmodule

// File: rtl/gpio_nib_regs.sv
module gpio_nib_regs
  import gpio_nib_pkg::*;
#(
  parameter int PINS   = 4,
  parameter int MODE_W = 2,
  localparam int CTRL_W = PINS * MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [PINS-1:0]   pend_i,
  input  logic [PINS-1:0]   lvl_i,
  output logic [CTRL_W-1:0] mode_o,
  output logic [PINS-1:0]   dout_o,
  output logic [PINS-1:0]   reload_o,
  output logic [PINS-1:0]   clr_o,
  output logic [CTRL_W-1:0] rdata_o
);
  localparam int PAD_W = CTRL_W - PINS;

  logic [CTRL_W-1:0] mode_q, rdata_q;
  logic [PINS-1:0]   dout_q;
  logic              mode_wr, pend_wr;

  assign mode_wr = wr_i && addr_i == RA_MODE;
  assign pend_wr = wr_i && addr_i == RA_PEND;

  for (genvar i = 0; i < PINS; i++) begin : g_fld
    assign reload_o[i] = mode_wr &&
      (wdata_i[MODE_W*i +: MODE_W] != mode_q[MODE_W*i +: MODE_W]);
  end

  assign clr_o = pend_wr ? wdata_i[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      dout_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (mode_wr) mode_q <= wdata_i;
      if (wr_i && addr_i == RA_DOUT) dout_q <= wdata_i[PINS-1:0];
      unique case (addr_i)
        RA_MODE: rdata_q <= mode_q;
        RA_DOUT: rdata_q <= {{PAD_W{1'b0}}, dout_q};
        RA_PEND: rdata_q <= {{PAD_W{1'b0}}, pend_i};
        default: rdata_q <= {{PAD_W{1'b0}}, lvl_i};
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign dout_o  = dout_q;
  assign rdata_o = rdata_q;

  // R11: a mode write is visible at address 0 on the read that follows
  p_mode_rb_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_wr) |=> (mode_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_nibble_irq.sv
module gpio_nibble_irq
  import gpio_nib_pkg::*;
#(
  parameter int PINS        = 4,
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic [PINS*MODE_W-1:0]   bus_wdata,
  output logic [PINS*MODE_W-1:0]   bus_rdata,
  input  logic [PINS-1:0]          pin_in,
  output logic [PINS-1:0]          pin_out,
  output logic [PINS-1:0]          pin_oe,
  output logic                     irq
);
  localparam int CTRL_W = PINS * MODE_W;

  logic [PINS-1:0]   lvl, pend, reload, clr, dout;
  logic [CTRL_W-1:0] mode_vec;
  logic              irq_q;

  gpio_nib_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (pin_in), .q_o (lvl)
  );

  gpio_nib_regs #(.PINS(PINS), .MODE_W(MODE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .wdata_i  (bus_wdata),
    .pend_i   (pend),
    .lvl_i    (lvl),
    .mode_o   (mode_vec),
    .dout_o   (dout),
    .reload_o (reload),
    .clr_o    (clr),
    .rdata_o  (bus_rdata)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_nib_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .mode_i   (pin_mode_e'(mode_vec[MODE_W*i +: MODE_W])),
      .sync_i   (lvl[i]),
      .reload_i (reload[i]),
      .clr_i    (clr[i]),
      .pend_o   (pend[i])
    );
    assign pin_oe[i] = (mode_vec[MODE_W*i +: MODE_W] == MD_DRIVE);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end

  assign pin_out = dout;
  assign irq     = irq_q;

  // R7: shared request lags the merged flags by one clock
  p_irq_merge_r7: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|pend));
  // R9: a mode write alone never raises a flag for a pin whose level is steady
  p_no_false_r9: assert property (@(posedge clk) disable iff (rst)
    (reload[0] && $stable(lvl[0])) |=> !$rose(pend[0]));
endmodule

// File: tb/tb_gpio_nibble_irq.sv
module tb_gpio_nibble_irq;
  localparam int CLK_P = 10;

  logic       clk = 0, rst = 1;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [3:0] pin_in = 0, pin_out, pin_oe;
  logic       irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_nibble_irq dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  bit [3:0] s1, s2, pv, pd, od;
  bit [7:0] md, rd;
  bit       iq;

  always @(posedge clk) begin
    bit [3:0] npd, npv;
    bit [7:0] nrd;
    if (rst) begin
      s1 = 0; s2 = 0; pv = 0; pd = 0; od = 0; md = 0; rd = 0; iq = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        int f;
        bit hit, clr, rel;
        f = (md >> (2*i)) & 3;
        hit = (f == 0 && pv[i] && !s2[i]) || (f == 1 && pv[i] != s2[i]) ||
              (f == 3 && !pv[i] && s2[i]);
        clr = bus_wr && bus_addr == 2 && bus_wdata[i];
        rel = bus_wr && bus_addr == 0 && (((bus_wdata >> (2*i)) & 3) != f);
        npd[i] = hit ? 1'b1 : (clr ? 1'b0 : pd[i]);
        npv[i] = (rel || f != 2) ? s2[i] : pv[i];
      end
      case (bus_addr)
        0: nrd = md;
        1: nrd = {4'b0, od};
        2: nrd = {4'b0, pd};
        default: nrd = {4'b0, s2};
      endcase
      iq = |pd;
      rd = nrd;
      pd = npd;
      pv = npv;
      if (bus_wr && bus_addr == 0) md = bus_wdata;
      if (bus_wr && bus_addr == 1) od = bus_wdata[3:0];
      s2 = s1;
      s1 = pin_in;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit [3:0] eoe;
      for (int i = 0; i < 4; i++) eoe[i] = ((md >> (2*i)) & 3) == 2;
      chk("R5", "pin_oe", pin_oe, eoe);
      chk("R5", "pin_out", pin_out, od);
      chk("R7", "irq", irq, iq);
      chk("R11", "bus_rdata", bus_rdata, rd);
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdreg(input bit [1:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_wr = 0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setpin(int i, bit v);
    @(negedge clk); pin_in[i] = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    idle(3); rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1", "irq", irq, 0);
    chk("R1", "pin_oe", pin_oe, 0);
    rdreg(0, v); chk("R1", "mode", v, 0);
    rdreg(2, v); chk("R1", "pend", v, 0);
    // R2 falling only in default mode
    setpin(0, 1); idle(5);
    rdreg(2, v); chk("R2", "pend after rise", v, 0);
    setpin(0, 0); idle(5);
    rdreg(2, v); chk("R2", "pend after fall", v, 1);
    chk("R7", "irq set", irq, 1);
    // R8 write-zero keeps, write-one clears
    wr(2, 8'h00); idle(1);
    rdreg(2, v); chk("R8", "pend after zero write", v, 1);
    wr(2, 8'h01); idle(1);
    rdreg(2, v); chk("R8", "pend after clear", v, 0);
    // R4 and R10 rising mode on pin 0 with latency
    wr(0, 8'h03); idle(2);
    setpin(0, 1);
    idle(2); chk("R10", "irq two edges later", irq, 0);
    idle(1); chk("R10", "irq three edges later", irq, 0);
    idle(1); chk("R10", "irq four edges later", irq, 1);
    wr(2, 8'h0F); setpin(0, 0); idle(5);
    rdreg(2, v); chk("R4", "pend after fall", v, 0);
    // R3 both edges on pin 1 (bits 3:2)
    wr(0, 8'h07); idle(2);
    setpin(1, 1); idle(5);
    rdreg(2, v); chk("R3", "pend after rise", v, 2);
    wr(2, 8'h02); setpin(1, 0); idle(5);
    rdreg(2, v); chk("R3", "pend after fall", v, 2);
    wr(2, 8'h0F);
    // R6 and R5: pin 3 drive via bits 7:6
    wr(0, 8'h87); idle(1);
    chk("R6", "oe", pin_oe, 4'b1000);
    wr(1, 8'h0F); idle(1);
    chk("R5", "pin_out", pin_out, 4'hF);
    setpin(3, 1); idle(4); setpin(3, 0); idle(4); setpin(3, 1); idle(5);
    rdreg(2, v); chk("R5", "pend driven pin", v, 0);
    // R11 level readback
    rdreg(3, v); chk("R11", "levels", v, 8);
    // R9 switch pin 3 to rising while its level is high
    wr(0, 8'hC7); idle(6);
    rdreg(2, v); chk("R9", "pend after mode change", v, 0);
    // random mixing
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) setpin($urandom_range(0, 3), $urandom_range(0, 1));
      else if (r == 4) wr(0, 8'($urandom));
      else if (r == 5) wr(2, 8'($urandom));
      else if (r == 6) wr(1, 8'($urandom));
      else begin @(negedge clk); bus_addr = 2'($urandom); end
    end
    idle(5);
    finish_run();
  end
endmodule